// File: doc/BRIEF.md
# Transport-Stream Character Slot Sequencer

This block decides, on every clock, what one character slot toward an 8b/10b serializer carries. In video mode it forwards a byte, a control/data flag and an enable that an upstream video path has already prepared. In transport mode it pulls bytes from a FIFO and sends them as data characters. Whenever no byte is ready, it sends the comma fill code. A single mode input selects between the two paths. The serializer needs only one input port.

Transport bytes can come from two kinds of FIFO. A clocked FIFO raises a level that means "a byte is valid this cycle". An asynchronous FIFO signals each ready byte with an edge on a strobe line. That line is resynchronised through a flop chain inside the block. Each accepted byte produces exactly one read pulse toward the FIFO. A mode change always costs one fill slot, so that the serializer never sees a character from the old path next to one from the new path.

Top module: `asi_tx_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next slot is `tx_byte`=0xBC, `tx_special`=1 and `tx_enable`=0, and `fifo_read` stays 0. After reset the block runs in video mode.
- R2: In settled transport mode (`asi_mode`=1 and also 1 in the previous slot), a high `sync_valid` raises `fifo_read` in the same cycle. The next slot then carries `fifo_byte` unchanged, with `tx_special`=0 (data) and `tx_enable`=1.
- R3: In settled transport mode with no byte available, the next slot is the fill code: `tx_byte`=0xBC (K28.5), `tx_special`=1 (control) and `tx_enable`=1, and `fifo_read` stays 0.
- R4: Each rising edge of `async_ready` passes through a two-flop synchroniser. It becomes a read request in the cycle after the second flop captures it. If `sync_valid` is low in that cycle, the request is served at once with one `fifo_read` pulse and a data slot.
- R5: `sync_valid` has priority. Asynchronous requests that arrive while it is high are queued, up to PEND_MAX (default 3). Each queued request is later served with exactly one read and one data slot.
- R6: In a slot where `asi_mode` differs from its value in the previous slot, the next slot is a fill code with `tx_enable`=1 and no read. The new mode takes effect from the following slot.
- R7: In settled video mode, `vid_byte`, `vid_special` and `vid_en` appear on `tx_byte`, `tx_special` and `tx_enable` one cycle later.
- R8: Synchronised `async_ready` edges that occur while transport mode is not settled are discarded. Queued requests are cleared when that mode ends. `fifo_read` is never high unless transport mode is settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| asi_mode | input | 1 | 1 selects transport path, 0 selects video path |
| vid_byte | input | 8 | Video character byte |
| vid_special | input | 1 | Video character control flag |
| vid_en | input | 1 | Video character enable |
| sync_valid | input | 1 | Clocked FIFO holds a valid byte this cycle |
| async_ready | input | 1 | Asynchronous FIFO byte-ready strobe (edge) |
| fifo_byte | input | 8 | Byte offered by the FIFO |
| fifo_read | output | 1 | Read pulse, one per accepted byte |
| tx_byte | output | 8 | Registered slot byte to serializer |
| tx_special | output | 1 | 1 = control character, 0 = data |
| tx_enable | output | 1 | Slot enable toward serializer |

## Verification
The assertions assume that `fifo_byte` is valid in every cycle where `fifo_read` is high. They also assume that the asynchronous source never has more than PEND_MAX requests outstanding. The stimulus spaces `async_ready` edges at least two cycles apart and limits the number of edges placed inside a long `sync_valid` burst to stay within the queue limit. All inputs change away from the sampling edge, including `async_ready`, so the synchroniser delay is deterministic and the reference model can predict the exact read cycle.

// File: rtl/asi_tx_pkg.sv
package asi_tx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] COMMA_FILL = 8'hBC;

  typedef enum logic [2:0] {
    SLOT_RESET,
    SLOT_SWITCH,
    SLOT_VIDEO,
    SLOT_DATA,
    SLOT_FILL
  } slot_kind_e;
endpackage

// File: rtl/asi_edge_sync.sv
module asi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/asi_read_arbiter.sv
module asi_read_arbiter #(
  parameter int PEND_MAX = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic sync_valid,
  input  logic edge_strobe,
  output logic take_sync,
  output logic take_async
);
  localparam int CW = $clog2(PEND_MAX + 1);
  localparam logic [CW-1:0] CMAX = CW'(PEND_MAX);

  logic [CW-1:0] pend_cnt;
  logic          have_req;

  assign have_req   = (pend_cnt != '0) | edge_strobe;
  assign take_sync  = active & sync_valid;
  assign take_async = active & ~sync_valid & have_req;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      pend_cnt <= '0;
    end else begin
      case ({edge_strobe, take_async})
        2'b10:   if (pend_cnt != CMAX) pend_cnt <= pend_cnt + 1'b1;
        2'b01:   pend_cnt <= pend_cnt - 1'b1;
        default: pend_cnt <= pend_cnt;
      endcase
    end
  end
endmodule

// File: rtl/asi_slot_mux.sv
module asi_slot_mux
  import asi_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              asi_mode,
  input  logic              take_data,
  input  logic [BYTE_W-1:0] fifo_byte,
  input  logic [BYTE_W-1:0] vid_byte,
  input  logic              vid_special,
  input  logic              vid_en,
  output logic              mode_q,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_special,
  output logic              tx_enable
);
  slot_kind_e kind;

  always_comb begin
    if (rst)                    kind = SLOT_RESET;
    else if (asi_mode != mode_q) kind = SLOT_SWITCH;
    else if (!mode_q)           kind = SLOT_VIDEO;
    else if (take_data)         kind = SLOT_DATA;
    else                        kind = SLOT_FILL;
  end

  always_ff @(posedge clk) begin
    mode_q <= rst ? 1'b0 : asi_mode;
    case (kind)
      SLOT_VIDEO: begin
        tx_byte    <= vid_byte;
        tx_special <= vid_special;
        tx_enable  <= vid_en;
      end
      SLOT_DATA: begin
        tx_byte    <= fifo_byte;
        tx_special <= 1'b0;
        tx_enable  <= 1'b1;
      end
      SLOT_RESET: begin
        tx_byte    <= COMMA_FILL;
        tx_special <= 1'b1;
        tx_enable  <= 1'b0;
      end
      default: begin
        tx_byte    <= COMMA_FILL;
        tx_special <= 1'b1;
        tx_enable  <= 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/asi_tx_sequencer.sv
module asi_tx_sequencer
  import asi_tx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PEND_MAX    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              asi_mode,
  input  logic [BYTE_W-1:0] vid_byte,
  input  logic              vid_special,
  input  logic              vid_en,
  input  logic              sync_valid,
  input  logic              async_ready,
  input  logic [BYTE_W-1:0] fifo_byte,
  output logic              fifo_read,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_special,
  output logic              tx_enable
);
  logic mode_q;
  logic active;
  logic edge_strobe;
  logic take_sync;
  logic take_async;

  assign active    = asi_mode & mode_q & ~rst;
  assign fifo_read = take_sync | take_async;

  asi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (async_ready),
    .rise (edge_strobe)
  );

  asi_read_arbiter #(.PEND_MAX(PEND_MAX)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .active      (active),
    .sync_valid  (sync_valid),
    .edge_strobe (edge_strobe),
    .take_sync   (take_sync),
    .take_async  (take_async)
  );

  asi_slot_mux u_mux (
    .clk         (clk),
    .rst         (rst),
    .asi_mode    (asi_mode),
    .take_data   (fifo_read),
    .fifo_byte   (fifo_byte),
    .vid_byte    (vid_byte),
    .vid_special (vid_special),
    .vid_en      (vid_en),
    .mode_q      (mode_q),
    .tx_byte     (tx_byte),
    .tx_special  (tx_special),
    .tx_enable   (tx_enable)
  );
endmodule

// File: rtl/asi_tx_sequencer_chk.sv
module asi_tx_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       asi_mode,
  input logic       mode_q,
  input logic [7:0] vid_byte,
  input logic       vid_special,
  input logic       vid_en,
  input logic       sync_valid,
  input logic [7:0] fifo_byte,
  input logic       fifo_read,
  input logic [7:0] tx_byte,
  input logic       tx_special,
  input logic       tx_enable
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen === 1'b1) begin
      assert_reset_fill_R1: assert (tx_byte == 8'hBC && tx_special && !tx_enable && !fifo_read)
        else $error("R1 reset slot wrong");
    end
  end

  assert_sync_read_R2: assert property (@(posedge clk) disable iff (rst)
    (fifo_read && sync_valid) |=> (!tx_special && tx_enable && tx_byte == $past(fifo_byte)));

  assert_fill_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (asi_mode && mode_q && !fifo_read) |=> (tx_special && tx_enable && tx_byte == 8'hBC));

  assert_switch_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (asi_mode != mode_q) |-> (!fifo_read ##1 (tx_special && tx_enable && tx_byte == 8'hBC)));

  assert_video_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (!asi_mode && !mode_q) |=> (tx_byte == $past(vid_byte) && tx_special == $past(vid_special)
                                && tx_enable == $past(vid_en)));

  assert_no_read_unsettled_R8: assert property (@(posedge clk) disable iff (rst)
    !(asi_mode && mode_q) |-> !fifo_read);
endmodule

bind asi_tx_sequencer asi_tx_sequencer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .asi_mode    (asi_mode),
  .mode_q      (mode_q),
  .vid_byte    (vid_byte),
  .vid_special (vid_special),
  .vid_en      (vid_en),
  .sync_valid  (sync_valid),
  .fifo_byte   (fifo_byte),
  .fifo_read   (fifo_read),
  .tx_byte     (tx_byte),
  .tx_special  (tx_special),
  .tx_enable   (tx_enable)
);

// File: tb/sim_asi_tx_sequencer.sv
module sim_asi_tx_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       asi_mode = 1'b0;
  logic [7:0] vid_byte = 8'h00;
  logic       vid_special = 1'b0;
  logic       vid_en = 1'b0;
  logic       sync_valid = 1'b0;
  logic       async_ready = 1'b0;
  logic [7:0] fifo_byte = 8'h00;
  logic       fifo_read;
  logic [7:0] tx_byte;
  logic       tx_special;
  logic       tx_enable;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_mode = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0, m_cnt = 0;
  int exp_byte = 8'hBC, exp_special = 1, exp_enable = 0;
  string exp_req = "R1";
  bit have_exp = 0;

  always #2 clk = ~clk;

  asi_tx_sequencer u0 (
    .clk(clk), .rst(rst), .asi_mode(asi_mode), .vid_byte(vid_byte),
    .vid_special(vid_special), .vid_en(vid_en), .sync_valid(sync_valid),
    .async_ready(async_ready), .fifo_byte(fifo_byte), .fifo_read(fifo_read),
    .tx_byte(tx_byte), .tx_special(tx_special), .tx_enable(tx_enable)
  );

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one slot: called at a falling edge; returns at the next falling edge
  task automatic slot(bit r, bit md, bit sv, bit ar, int fb, int vb, bit vs, bit ve);
    int strobe, active, tk_s, tk_a, rd;
    string rreq;
    if (have_exp) begin
      check(exp_req, tx_byte, exp_byte, "tx_byte");
      check(exp_req, tx_special, exp_special, "tx_special");
      check(exp_req, tx_enable, exp_enable, "tx_enable");
    end
    rst = r; asi_mode = md; sync_valid = sv; async_ready = ar;
    fifo_byte = fb[7:0]; vid_byte = vb[7:0]; vid_special = vs; vid_en = ve;
    #1;
    strobe = m_s2 & ~m_s3;
    active = md & m_mode & !r;
    tk_s = active & sv;
    tk_a = active & !sv & ((m_cnt > 0) | strobe);
    rd = tk_s | tk_a;
    rreq = tk_s ? "R2" : (tk_a ? "R4" : (r ? "R1" : (active ? "R3" : "R8")));
    if (m_cnt > 0 && tk_a) rreq = "R5";
    check(rreq, fifo_read, rd, "fifo_read");
    have_exp = 1;
    if (r) begin
      exp_byte = 8'hBC; exp_special = 1; exp_enable = 0; exp_req = "R1";
    end else if (md != m_mode) begin
      exp_byte = 8'hBC; exp_special = 1; exp_enable = 1; exp_req = "R6";
    end else if (m_mode == 0) begin
      exp_byte = vb & 8'hFF; exp_special = vs; exp_enable = ve; exp_req = "R7";
    end else if (rd) begin
      exp_byte = fb & 8'hFF; exp_special = 0; exp_enable = 1; exp_req = tk_s ? "R2" : "R5";
    end else begin
      exp_byte = 8'hBC; exp_special = 1; exp_enable = 1; exp_req = "R3";
    end
    if (r) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_mode = 0;
    end else begin
      if (!active) m_cnt = 0;
      else if (strobe && !tk_a && m_cnt < 3) m_cnt++;
      else if (!strobe && tk_a) m_cnt--;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ar; m_mode = md;
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset
    for (int i = 0; i < 3; i++) slot(1, 1, 1, 0, 8'h11, 8'h22, 0, 1);
    // R7: video pass-through patterns
    for (int i = 0; i < 6; i++) slot(0, 0, 1, 0, 8'h55, i * 41 + 3, i[0], i != 2);
    // R6: switch into transport mode, then R3 idle fill
    slot(0, 1, 1, 0, 8'hA1, 0, 0, 0);
    for (int i = 0; i < 3; i++) slot(0, 1, 0, 0, 8'hA2, 0, 0, 0);
    // R2: clocked FIFO bursts with gaps
    for (int i = 0; i < 8; i++) slot(0, 1, i != 3 && i != 6, 0, i * 29 + 7, 0, 0, 0);
    // R4: single asynchronous strobes, served at once
    for (int i = 0; i < 12; i++) slot(0, 1, 0, (i % 6) < 3, 8'hC0 + i, 0, 0, 0);
    // R5: edges arriving under a long sync burst are queued then served
    for (int i = 0; i < 12; i++) slot(0, 1, 1, i[1], 8'h30 + i, 0, 0, 0);
    for (int i = 0; i < 8; i++) slot(0, 1, 0, 0, 8'h60 + i, 0, 0, 0);
    // R8: queued requests dropped on mode exit, edges ignored in video
    for (int i = 0; i < 6; i++) slot(0, 1, 1, i[1], 8'h70 + i, 0, 0, 0);
    slot(0, 0, 1, 0, 8'h77, 8'h12, 1, 1);
    for (int i = 0; i < 10; i++) slot(0, 0, 1, i[1], 8'h78, i + 8'h40, 0, 1);
    // R6 back into transport while async line toggles
    slot(0, 1, 0, 1, 8'h90, 0, 0, 0);
    for (int i = 0; i < 6; i++) slot(0, 1, 0, i[1], 8'h91 + i, 0, 0, 0);
    // R1: reset in the middle of traffic
    slot(1, 1, 1, 0, 8'h99, 0, 0, 0);
    for (int i = 0; i < 4; i++) slot(0, 1, i > 1, 0, 8'h9A + i, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule